// File: doc/BRIEF.md
# Port Error Rate Threshold Monitor

This block watches the error reporting of one serial link port. Each clock cycle it may receive one transmission error event tagged with a type. Event types that are switched on in an enable mask are counted in an 8-bit running count. The count stops rising at a programmable ceiling. The count is compared with two programmable levels: a degraded level and a failed level. Reaching a level sets a sticky status bit.

Alongside the error count, a small state machine follows the link's retry behaviour. It counts retry events that arrive without an accept between them. When that run reaches a 4-bit limit, it raises a sticky retry-exceeded bit. Any accepted packet ends the run. The recommended retry limit is 15.

A single register-write port programs the block. It sets the enable mask, the ceiling code, the two count levels, the retry limit and the interrupt enables. The same port also clears status bits by writing ones. The interrupt is the OR of the status bits whose interrupt enable is set.

The retry state machine has three states:
- `RT_IDLE`: no retries outstanding.
- `RT_RUN`: one or more consecutive retries, below the limit.
- `RT_TRIP`: the limit has been reached.

Its transitions are:
- IDLE→RUN: a retry that does not reach the limit.
- IDLE→TRIP or RUN→TRIP: a retry that reaches a non-zero limit. This is the only transition that sets the retry-exceeded bit.
- RUN→RUN and TRIP→TRIP: further retries. The run counter rises and saturates at 15.
- RUN→IDLE and TRIP→IDLE: any accept. The run is cleared to zero.

Top module: `lnk_errmon`

## Requirements
- R1: An error event (`err_vld`=1) of type t adds to the count only if bit t of the enable mask is 1. The enable mask is written at address 0, data bits [3:0], and resets to 4'b1111.
- R2: Each counted event adds exactly 1 to `err_count` in the same clock edge. The count saturates at a ceiling chosen by a code written at address 1, bits [1:0]: code 0 gives 16, code 1 gives 32, code 2 gives 64, and code 3 gives 255. The code resets to 3.
- R3: `st_degraded` is set on the edge where the updated count is greater than or equal to the degraded level (address 2, 8 bits), provided that level is non-zero. It then stays set.
- R4: `st_failed` is set on the edge where the updated count is greater than or equal to the failed level (address 3, 8 bits), provided that level is non-zero. It then stays set.
- R5: When the number of consecutive retry events reaches the retry limit (address 4, bits [3:0], non-zero), `st_rty_exc` is set on the edge of that retry. It then stays set.
- R6: An accept event clears the consecutive-retry run. This holds even if a retry arrives in the same cycle.
- R7: Writing address 5 clears status bits whose data bit is 1: bit 0 clears degraded, bit 1 clears failed, bit 2 clears retry-exceeded. Data bits that are 0 leave their status bit unchanged. If a set condition is present in the same cycle, the set wins.
- R8: `irq` is the OR of the status bits ANDed with the interrupt-enable mask. The mask is written at address 6, bits [2:0], with the same bit order as the status bits in R7. It resets to 3'b111. `irq` follows the status bits with no added delay.
- R9: A level or retry limit of 0 never sets its status bit. All three reset to 0.
- R10: After reset, `err_count` is 0, all status bits are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_vld | input | 1 | One transmission error event this cycle |
| err_type | input | 2 | Type index of the error event |
| rty_evt | input | 1 | Retry event this cycle |
| acc_evt | input | 1 | Packet accept event this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| err_count | output | 8 | Running error count |
| st_degraded | output | 1 | Sticky degraded status |
| st_failed | output | 1 | Sticky failed status |
| st_rty_exc | output | 1 | Sticky retry-exceeded status |
| irq | output | 1 | Error interrupt |

## Verification
A wrong count shows on `err_count` right after the edge that took the event. It also shows as a status bit rising one or more events too early or too late. A retry state machine in the wrong state, or a run counter that failed to clear, shows only at the edge of the retry that should or should not trip. For that reason the bench drives retry sequences split by accepts, including an accept and a retry in the same cycle. A broken sticky or clear path shows on the status pins one edge after the write that clears them.

// File: rtl/lnk_errmon_pkg.sv
package lnk_errmon_pkg;

    typedef enum logic [1:0] {
        RT_IDLE = 2'd0,
        RT_RUN  = 2'd1,
        RT_TRIP = 2'd2
    } rt_state_e;

    localparam int ST_W    = 3;
    localparam int ST_DEG  = 0;
    localparam int ST_FAIL = 1;
    localparam int ST_RTY  = 2;

    localparam logic [2:0] A_MASK = 3'd0;
    localparam logic [2:0] A_CEIL = 3'd1;
    localparam logic [2:0] A_DEG  = 3'd2;
    localparam logic [2:0] A_FAIL = 3'd3;
    localparam logic [2:0] A_RTY  = 3'd4;
    localparam logic [2:0] A_W1C  = 3'd5;
    localparam logic [2:0] A_IEN  = 3'd6;

    localparam logic [1:0] CEIL_OPEN = 2'b11;

endpackage

// File: rtl/lnk_errmon_cfg.sv
module lnk_errmon_cfg
    import lnk_errmon_pkg::*;
#(
    parameter int NTYPES = 4,
    parameter int CNT_W  = 8,
    parameter int RET_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NTYPES-1:0] en_mask,
    output logic [1:0]        ceil_code,
    output logic [CNT_W-1:0]  deg_thr,
    output logic [CNT_W-1:0]  fail_thr,
    output logic [RET_W-1:0]  rty_thr,
    output logic [ST_W-1:0]   irq_en,
    output logic [ST_W-1:0]   w1c
);

    logic unused_hi;
    assign unused_hi = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_mask   <= '1;
            ceil_code <= CEIL_OPEN;
            deg_thr   <= '0;
            fail_thr  <= '0;
            rty_thr   <= '0;
            irq_en    <= '1;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_MASK:  en_mask   <= wr_data[NTYPES-1:0];
                A_CEIL:  ceil_code <= wr_data[1:0];
                A_DEG:   deg_thr   <= wr_data;
                A_FAIL:  fail_thr  <= wr_data;
                A_RTY:   rty_thr   <= wr_data[RET_W-1:0];
                A_IEN:   irq_en    <= wr_data[ST_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        w1c = '0;
        if (wr_en && wr_addr == A_W1C) w1c = wr_data[ST_W-1:0];
    end

endmodule

// File: rtl/lnk_errmon_cnt.sv
module lnk_errmon_cnt
    import lnk_errmon_pkg::*;
#(
    parameter int NTYPES = 4,
    parameter int CNT_W  = 8,
    parameter int BASE   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      err_vld,
    input  logic [$clog2(NTYPES)-1:0] err_type,
    input  logic [NTYPES-1:0]         en_mask,
    input  logic [1:0]                ceil_code,
    output logic [CNT_W-1:0]          cnt_q,
    output logic [CNT_W-1:0]          cnt_d
);

    logic             hit;
    logic [CNT_W-1:0] limit;

    always_comb begin
        hit   = err_vld && en_mask[err_type];
        limit = (ceil_code == CEIL_OPEN) ? '1 : (CNT_W'(BASE) << ceil_code);
        cnt_d = (hit && cnt_q < limit) ? cnt_q + 1'b1 : cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

    p_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && !en_mask[err_type]) |=> $stable(cnt_q));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vld |=> $stable(cnt_q));

endmodule

// File: rtl/lnk_errmon_retry.sv
module lnk_errmon_retry
    import lnk_errmon_pkg::*;
#(
    parameter int RET_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rty_evt,
    input  logic             acc_evt,
    input  logic [RET_W-1:0] rty_thr,
    output logic             trip
);

    rt_state_e        state_q, state_n;
    logic [RET_W-1:0] run_q, run_n, run_inc;
    logic             reach;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RT_IDLE;
            run_q   <= '0;
        end else begin
            state_q <= state_n;
            run_q   <= run_n;
        end
    end

    always_comb begin
        run_inc = (run_q == '1) ? run_q : run_q + 1'b1;
        reach   = (rty_thr != '0) && (run_inc >= rty_thr);
        state_n = state_q;
        run_n   = run_q;
        unique case (state_q)
            RT_IDLE: begin
                if (!acc_evt && rty_evt) begin
                    run_n   = run_inc;
                    state_n = reach ? RT_TRIP : RT_RUN;
                end
            end
            RT_RUN: begin
                if (acc_evt) begin
                    run_n   = '0;
                    state_n = RT_IDLE;
                end else if (rty_evt) begin
                    run_n   = run_inc;
                    state_n = reach ? RT_TRIP : RT_RUN;
                end
            end
            RT_TRIP: begin
                if (acc_evt) begin
                    run_n   = '0;
                    state_n = RT_IDLE;
                end else if (rty_evt) begin
                    run_n = run_inc;
                end
            end
            default: begin
                run_n   = '0;
                state_n = RT_IDLE;
            end
        endcase
    end

    always_comb begin
        trip = (state_q != RT_TRIP) && (state_n == RT_TRIP);
    end

    p_acc_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_evt |=> (run_q == '0 && state_q == RT_IDLE));

    p_trip_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> (rty_evt && !acc_evt && rty_thr != '0));

    p_trip_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (state_q == RT_TRIP));

endmodule

// File: rtl/lnk_errmon_stat.sv
module lnk_errmon_stat
    import lnk_errmon_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic [CNT_W-1:0] deg_thr,
    input  logic [CNT_W-1:0] fail_thr,
    input  logic             trip,
    input  logic [ST_W-1:0]  w1c,
    input  logic [ST_W-1:0]  irq_en,
    output logic [ST_W-1:0]  stat_q,
    output logic             irq
);

    logic [ST_W-1:0] set;

    always_comb begin
        set          = '0;
        set[ST_DEG]  = (deg_thr  != '0) && (cnt_d >= deg_thr);
        set[ST_FAIL] = (fail_thr != '0) && (cnt_d >= fail_thr);
        set[ST_RTY]  = trip;
        irq          = |(stat_q & irq_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= set | (stat_q & ~w1c);
    end

    for (genvar i = 0; i < ST_W; i++) begin : g_chk
        p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[i] && !w1c[i]) |=> stat_q[i]);
    end

    p_deg_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (deg_thr == '0 && !stat_q[ST_DEG]) |=> !stat_q[ST_DEG]);

    p_fail_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_thr == '0 && !stat_q[ST_FAIL]) |=> !stat_q[ST_FAIL]);

endmodule

// File: rtl/lnk_errmon.sv
module lnk_errmon
    import lnk_errmon_pkg::*;
#(
    parameter int NTYPES = 4,
    parameter int CNT_W  = 8,
    parameter int RET_W  = 4,
    parameter int BASE   = 16,
    localparam int TW    = $clog2(NTYPES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_vld,
    input  logic [TW-1:0]    err_type,
    input  logic             rty_evt,
    input  logic             acc_evt,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] err_count,
    output logic             st_degraded,
    output logic             st_failed,
    output logic             st_rty_exc,
    output logic             irq
);

    logic [NTYPES-1:0] en_mask;
    logic [1:0]        ceil_code;
    logic [CNT_W-1:0]  deg_thr, fail_thr, cnt_d;
    logic [RET_W-1:0]  rty_thr;
    logic [ST_W-1:0]   irq_en, w1c, stat_q;
    logic              trip;

    lnk_errmon_cfg #(.NTYPES(NTYPES), .CNT_W(CNT_W), .RET_W(RET_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .en_mask(en_mask), .ceil_code(ceil_code),
        .deg_thr(deg_thr), .fail_thr(fail_thr), .rty_thr(rty_thr),
        .irq_en(irq_en), .w1c(w1c)
    );

    lnk_errmon_cnt #(.NTYPES(NTYPES), .CNT_W(CNT_W), .BASE(BASE)) u_cnt (
        .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_type(err_type),
        .en_mask(en_mask), .ceil_code(ceil_code), .cnt_q(err_count),
        .cnt_d(cnt_d)
    );

    lnk_errmon_retry #(.RET_W(RET_W)) u_retry (
        .clk(clk), .rst_n(rst_n), .rty_evt(rty_evt), .acc_evt(acc_evt),
        .rty_thr(rty_thr), .trip(trip)
    );

    lnk_errmon_stat #(.CNT_W(CNT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .cnt_d(cnt_d), .deg_thr(deg_thr),
        .fail_thr(fail_thr), .trip(trip), .w1c(w1c), .irq_en(irq_en),
        .stat_q(stat_q), .irq(irq)
    );

    assign st_degraded = stat_q[ST_DEG];
    assign st_failed   = stat_q[ST_FAIL];
    assign st_rty_exc  = stat_q[ST_RTY];

    p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_degraded || st_failed || st_rty_exc));

endmodule

// File: tb/lnk_errmon_bench.sv
module lnk_errmon_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       err_vld = 1'b0;
    logic [1:0] err_type = '0;
    logic       rty_evt = 1'b0;
    logic       acc_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] err_count;
    logic       st_degraded, st_failed, st_rty_exc, irq;

    int checks = 0;
    int errs   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lnk_errmon u_lnk_errmon (
        .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_type(err_type),
        .rty_evt(rty_evt), .acc_evt(acc_evt), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .err_count(err_count),
        .st_degraded(st_degraded), .st_failed(st_failed),
        .st_rty_exc(st_rty_exc), .irq(irq)
    );

    // {err_vld, err_type, expected count}, run with enable mask 4'b0101
    localparam logic [10:0] VEC [8] = '{
        {1'b1, 2'd0, 8'd1}, {1'b1, 2'd1, 8'd1}, {1'b1, 2'd2, 8'd2},
        {1'b1, 2'd3, 8'd2}, {1'b0, 2'd0, 8'd2}, {1'b1, 2'd2, 8'd3},
        {1'b1, 2'd1, 8'd3}, {1'b1, 2'd0, 8'd4}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; err_vld = 0; rty_evt = 0; acc_evt = 0; wr_en = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic burst(input int n, input logic [1:0] t);
        err_vld = 1'b1; err_type = t;
        repeat (n) @(negedge clk);
        err_vld = 1'b0;
    endtask

    task automatic evt(input logic r, input logic a);
        rty_evt = r; acc_evt = a;
        @(negedge clk);
        rty_evt = 1'b0; acc_evt = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        do_reset();
        chk("R10 count", err_count, 0);
        chk("R10 status", {st_degraded, st_failed, st_rty_exc}, 0);
        chk("R10 irq", irq, 0);

        // R1: per-type enable mask walked from the table
        wr(3'd0, 8'b0101);
        for (int i = 0; i < 8; i++) begin
            err_vld = VEC[i][10]; err_type = VEC[i][9:8];
            @(negedge clk);
            err_vld = 1'b0;
            chk($sformatf("R1 vec%0d", i), err_count, VEC[i][7:0]);
        end

        // R2: ceilings
        do_reset();
        wr(3'd1, 8'd0);
        burst(20, 2'd3);
        chk("R2 ceil16", err_count, 16);
        wr(3'd1, 8'd1);
        burst(20, 2'd1);
        chk("R2 ceil32", err_count, 32);
        wr(3'd1, 8'd3);
        burst(300, 2'd0);
        chk("R2 ceil255", err_count, 255);

        // R3 / R4 / R8
        do_reset();
        wr(3'd2, 8'd3);
        wr(3'd3, 8'd5);
        burst(2, 2'd0);
        chk("R3 below", st_degraded, 0);
        burst(1, 2'd0);
        chk("R3 reach", st_degraded, 1);
        chk("R4 below", st_failed, 0);
        chk("R8 irq on", irq, 1);
        burst(2, 2'd1);
        chk("R4 reach", st_failed, 1);
        wr(3'd6, 8'd0);
        chk("R8 masked", irq, 0);
        wr(3'd6, 8'b010);
        chk("R8 fail only", irq, 1);

        // R7: write-one-to-clear
        wr(3'd5, 8'd0);
        chk("R7 zero write", st_degraded, 1);
        wr(3'd2, 8'd0);
        wr(3'd5, 8'b001);
        chk("R7 clr deg", st_degraded, 0);
        @(negedge clk);
        chk("R7 deg stays", st_degraded, 0);
        chk("R7 fail kept", st_failed, 1);
        wr(3'd5, 8'b010);
        chk("R7 set wins", st_failed, 1);

        // R9: zero levels and limit
        do_reset();
        burst(10, 2'd2);
        chk("R9 deg off", st_degraded, 0);
        chk("R9 fail off", st_failed, 0);
        for (int i = 0; i < 20; i++) evt(1'b1, 1'b0);
        chk("R9 rty off", st_rty_exc, 0);

        // R5 / R6: consecutive retries
        do_reset();
        wr(3'd4, 8'd3);
        evt(1, 0); evt(1, 0); evt(0, 1); evt(1, 0); evt(1, 0);
        chk("R6 acc breaks run", st_rty_exc, 0);
        evt(1, 0);
        chk("R5 trip", st_rty_exc, 1);
        chk("R8 rty irq", irq, 1);
        wr(3'd5, 8'b100);
        chk("R7 clr rty", st_rty_exc, 0);
        evt(1, 1);
        evt(1, 0);
        chk("R6 acc with rty", st_rty_exc, 0);
        evt(1, 0);
        evt(1, 0);
        chk("R5 trip again", st_rty_exc, 1);

        do_reset();
        wr(3'd4, 8'd1);
        evt(1, 0);
        chk("R5 limit1", st_rty_exc, 1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule